// File: doc/BRIEF.md
# Token Bucket Rate Limiter

This block meters a stream of requests against a budget of tokens. An internal counter earns one token each time a programmable refill period elapses, and it never holds more than a programmable capacity. A requester raises `req_valid` and keeps it high. The block accepts the request in any cycle where at least one token is held, and each accepted request spends exactly one token. When the bucket is empty the request is not dropped: `req_ready` stays low until a new token arrives.

Tokens that go unspent build up to the capacity, so a burst as large as the capacity passes back to back. After that, requests are spaced out at the refill rate. The token count is visible at all times. The refill period and the capacity can be changed while the block runs.

Top module: `token_bucket_gate`

## Requirements
- R1: While reset is applied, and for two clock edges after `rst_n` rises, `req_ready` is low. In the first cycle after that, `token_count` equals `cfg_capacity`.
- R2: `req_ready` is high exactly when `token_count` is nonzero outside reset. `grant` is high in the same cycle as `req_valid && req_ready`. With `req_valid` low, `grant` stays low and the count does not fall.
- R3: Each cycle with `grant` high and no refill lowers `token_count` by exactly one at the next clock edge. With 3 tokens and a request held for 5 cycles, the first 3 cycles grant and the remaining cycles do not.
- R4: A request that meets an empty bucket stays pending with `req_ready` low. It is granted in the first cycle after a refill brings the count to one.
- R5: A refill value of N (N ≥ 1) adds one token on every Nth enabled clock edge, the first on the Nth edge after reset takes effect. A value of 0 behaves as 1.
- R6: A refill that arrives while the count equals the capacity, with no grant in that cycle, is discarded, and the count stays at the capacity.
- R7: A refill and a grant in the same cycle leave the count unchanged.
- R8: Lowering `cfg_capacity` makes `token_count` read as the new capacity at once, and the excess tokens are lost. A capacity of 0 blocks every request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is pending |
| req_ready | output | 1 | A token is available to accept a request |
| grant | output | 1 | A request is accepted and one token is spent this cycle |
| cfg_interval | input | IVL_W (16) | Clock edges per refilled token (0 treated as 1) |
| cfg_capacity | input | TOKEN_W (8) | Maximum number of tokens held |
| token_count | output | TOKEN_W (8) | Tokens currently held |

## Verification
The bench sends a request that outlasts the stored tokens. A design that drops or double-spends a token would grant a fourth time, or stop after two grants. With a refill period of four, the bench predicts the exact cycle of every refill and grant after reset. A timer that is off by one edge moves those grants by a cycle, and a design that drops stalled requests never grants again. With the bucket full, it checks refills alone and refills paired with a grant. A design that lets a full bucket overflow, or that treats a paired refill and grant as a net loss, shows a count one higher or one lower than expected. It also lowers the capacity at runtime and sets it to zero. A design that keeps the excess tokens, or still grants with zero capacity, is caught there.

// File: rtl/tkb_pkg.sv
package tkb_pkg;

  localparam int TKB_TOKEN_W_DEF = 8;
  localparam int TKB_IVL_W_DEF   = 16;
  localparam int TKB_SYNC_DEF    = 2;

  // per-cycle change request handed to the token store
  typedef struct packed {
    logic add;   // refill period elapsed
    logic take;  // a request is granted
  } tkb_step_t;

endpackage

// File: rtl/tkb_reset_sync.sv
module tkb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_core_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      logic [STAGES-1:0] sh_nxt;
      always_comb sh_nxt = {sh[STAGES-2:0], 1'b1};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= sh_nxt;
      end
      assign rst_core_n = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tkb_refill_timer.sv
module tkb_refill_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_core_n,
  input  logic             en,
  input  logic [IVL_W-1:0] ivl_cfg,
  output logic             tick
);

  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] cnt_d;
  logic [IVL_W-1:0] last;

  // last count value of a period; 0 and 1 both mean every edge
  always_comb begin
    last = (ivl_cfg == '0) ? '0 : ivl_cfg - 1'b1;
    tick = en && (cnt_q >= last);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cnt_q <= '0;
    else if (en)      cnt_q <= cnt_d;
  end

  // R5: back-to-back refills only when the period is a single edge
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && $past(tick)) |-> (ivl_cfg <= 1));

endmodule

// File: rtl/tkb_token_store.sv
module tkb_token_store
  import tkb_pkg::*;
#(
  parameter int TOKEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_core_n,
  input  logic               en,
  input  tkb_step_t          step,
  input  logic [TOKEN_W-1:0] cap,
  output logic [TOKEN_W-1:0] count
);

  localparam int SUM_W = TOKEN_W + 1;

  logic [TOKEN_W-1:0] stored_q;
  logic [TOKEN_W-1:0] stored_d;
  logic [TOKEN_W-1:0] eff;
  logic               take_ok;
  logic [SUM_W-1:0]   sum;

  // held value reads through the capacity; reset value all-ones reads as full
  always_comb begin
    eff     = (stored_q > cap) ? cap : stored_q;
    take_ok = step.take && (eff != '0);
    sum     = {1'b0, eff} + SUM_W'(step.add) - SUM_W'(take_ok);
    stored_d = (sum > {1'b0, cap}) ? cap : sum[TOKEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) stored_q <= '1;
    else if (en)     stored_q <= stored_d;
  end

  assign count = eff;

  // R3: a lone grant spends exactly one token
  a_r3_consume_one: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && step.take && !step.add) |=>
      ((cap != $past(cap)) || (count == $past(count) - 1'b1)));

  // R7: refill and grant together cancel
  a_r7_add_take_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && step.take && step.add) |=>
      ((cap != $past(cap)) || (count == $past(count))));

  // R6: refill into a full bucket is lost
  a_r6_discard_full: assert property (@(posedge clk) disable iff (!rst_core_n)
    (en && step.add && !step.take && (count == cap)) |=>
      ((cap != $past(cap)) || (count == $past(count))));

  // R6: every written value respects the capacity seen at the write
  a_r6_stored_bounded: assert property (@(posedge clk) disable iff (!rst_core_n)
    en |=> (stored_q <= $past(cap)));

endmodule

// File: rtl/token_bucket_gate.sv
module token_bucket_gate
  import tkb_pkg::*;
#(
  parameter int TOKEN_W     = TKB_TOKEN_W_DEF,
  parameter int IVL_W       = TKB_IVL_W_DEF,
  parameter int SYNC_STAGES = TKB_SYNC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  output logic               grant,
  input  logic [IVL_W-1:0]   cfg_interval,
  input  logic [TOKEN_W-1:0] cfg_capacity,
  output logic [TOKEN_W-1:0] token_count
);

  logic      rst_core_n;
  logic      run;
  logic      tick;
  tkb_step_t step;

  tkb_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  assign run = rst_core_n;

  tkb_refill_timer #(.IVL_W(IVL_W)) u_timer (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .en         (run),
    .ivl_cfg    (cfg_interval),
    .tick       (tick)
  );

  always_comb begin
    req_ready = run && (token_count != '0);
    grant     = req_valid && req_ready;
    step.add  = tick;
    step.take = grant;
  end

  tkb_token_store #(.TOKEN_W(TOKEN_W)) u_store (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .en         (run),
    .step       (step),
    .cap        (cfg_capacity),
    .count      (token_count)
  );

  // R1: bucket is full in the first running cycle
  a_r1_full_after_reset: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (token_count == cfg_capacity));

  // R4: a stalled cycle can gain at most the one refilled token
  a_r4_stall_no_gain: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !req_ready) |=> (token_count <= 1));

endmodule

// File: tb/token_bucket_gate_test.sv
module token_bucket_gate_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        grant;
  logic [15:0] cfg_interval;
  logic [7:0]  cfg_capacity;
  logic [7:0]  token_count;

  int n_chk;
  int n_bad;
  int cyc;

  token_bucket_gate uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .grant        (grant),
    .cfg_interval (cfg_interval),
    .cfg_capacity (cfg_capacity),
    .token_count  (token_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles, expected below 20000", cyc);
        finish_run();
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // leaves the bench 1 time unit after the first running-cycle negedge
  task automatic do_reset(int cap, int ivl, bit v);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_capacity = 8'(cap);
    cfg_interval = 16'(ivl);
    req_valid = v;
    repeat (3) @(negedge clk);
    #1 chk("R1 ready in reset", int'(req_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 ready during sync", int'(req_ready), 0);
    @(negedge clk);
    #1;
  endtask

  task automatic t_burst();
    do_reset(3, 1000, 1'b0);
    chk("R1 count full", int'(token_count), 3);
    chk("R2 ready with tokens", int'(req_ready), 1);
    for (int i = 0; i < 2; i++) begin
      chk("R2 no grant idle", int'(grant), 0);
      chk("R2 idle count", int'(token_count), 3);
      @(negedge clk); #1;
    end
    @(negedge clk);
    req_valid = 1'b1;
    #1;
    for (int i = 0; i < 6; i++) begin
      chk("R3 burst grant", int'(grant), (i < 3) ? 1 : 0);
      chk("R3 burst count", int'(token_count), (i < 3) ? 3 - i : 0);
      @(negedge clk); #1;
    end
    chk("R4 empty stalls", int'(req_ready), 0);
    req_valid = 1'b0;
  endtask

  task automatic t_refill();
    do_reset(2, 4, 1'b1);
    for (int k = 0; k < 13; k++) begin
      int ec;
      int eg;
      ec = (k == 0) ? 2 : (k == 1) ? 1 : ((k >= 4) && (k % 4 == 0)) ? 1 : 0;
      eg = ((k < 2) || ((k >= 4) && (k % 4 == 0))) ? 1 : 0;
      chk("R5 refill count", int'(token_count), ec);
      chk("R4 stalled request granted", int'(grant), eg);
      @(negedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic t_full_discard();
    do_reset(2, 1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      chk("R6 full discards", int'(token_count), 2);
      @(negedge clk); #1;
    end
  endtask

  task automatic t_same_cycle();
    do_reset(1, 1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      chk("R7 grant each cycle", int'(grant), 1);
      chk("R7 count held", int'(token_count), 1);
      @(negedge clk); #1;
    end
    do_reset(2, 0, 1'b1);
    for (int i = 0; i < 6; i++) begin
      chk("R5 zero period grant", int'(grant), 1);
      chk("R5 zero period count", int'(token_count), 2);
      @(negedge clk); #1;
    end
    req_valid = 1'b0;
  endtask

  task automatic t_cap_change();
    do_reset(3, 1000, 1'b0);
    chk("R8 start full", int'(token_count), 3);
    @(negedge clk);
    cfg_capacity = 8'd1;
    #1 chk("R8 lowered cap", int'(token_count), 1);
    @(negedge clk); #1;
    chk("R8 lowered cap held", int'(token_count), 1);
    @(negedge clk);
    cfg_capacity = 8'd0;
    req_valid = 1'b1;
    #1;
    for (int i = 0; i < 3; i++) begin
      chk("R8 zero cap ready", int'(req_ready), 0);
      chk("R8 zero cap grant", int'(grant), 0);
      @(negedge clk); #1;
    end
    @(negedge clk);
    cfg_capacity = 8'd3;
    req_valid = 1'b0;
    #1 chk("R8 excess lost", int'(token_count), 0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    cfg_interval = 16'd1000;
    cfg_capacity = 8'd3;
    t_burst();
    t_refill();
    t_full_discard();
    t_same_cycle();
    t_cap_change();
    finish_run();
  end

endmodule